// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block sits between a CPU register port and the transmit and receive shift engines of a serial port. It buffers received bytes and bytes waiting to be sent in two byte queues of `DEPTH` entries each. A write-only control register turns the queues on, empties either queue on demand, selects a level for receive interrupts and enables request lines for an external DMA engine. Reading the same address returns an interrupt identification word that names the highest pending cause.

The receive engine pushes bytes with `rx_push`, and the CPU pops them by reading the data address. The CPU fills the transmit queue by writing the data address, and the transmit engine drains it with `tx_pop`. The transmit-empty interrupt is raised at once when the transmit queue drains after having held at least two bytes. When the queue held only one byte, the interrupt waits `CHAR_TICKS` baud strobes. This gives software time to write the next byte without taking an interrupt.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset, `irq`, `dma_rx_req`, `dma_tx_req` and `tx_ready` are low, and a read of address 2 returns 0x01.
- R2: Control bit 0 enables the queues, and the identification word then reads bits 7:6 as 11. Any change of this bit empties both queues. A control write with bit 0 clear ignores bits 7:1. While disabled, each queue holds one byte, the receive level is one byte and no DMA request is raised.
- R3: Writing control bit 1 (with bit 0 set) empties the receive queue, and writing bit 2 empties the transmit queue. Neither bit is stored.
- R4: Control bits 7:6 choose the receive level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. The receive cause is pending while the receive queue holds at least that many bytes.
- R5: Both queues return bytes in arrival order. A push into a full queue is dropped.
- R6: When the transmit queue becomes empty after holding two or more bytes since the last transmit-empty event, the transmit-empty cause is pending in the same clock as the empty count.
- R7: Otherwise the transmit-empty cause becomes pending on the `CHAR_TICKS`-th `baud_tick` after the queue empties. A data write in the meantime cancels the wait.
- R8: A data write clears a pending transmit-empty cause. So does a read of address 2 that reports it as the top cause.
- R9: The identification word carries the cause in bits 3:1, from highest to lowest priority: line error 011, receive level 010, transmit empty 001. Bit 0 is 0 when any cause is pending, and `irq` is high exactly then.
- R10: With the queues enabled and control bit 3 set, `dma_rx_req` is high while the receive level is reached and `dma_tx_req` is high while the transmit queue is not full.
- R11: Control bits 5:4 and 31:8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 data, 2 control/identification |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| rx_push | input | 1 | Receive engine delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_line_err | input | 1 | Receive line error pending (level) |
| tx_pop | input | 1 | Transmit engine takes the head byte |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_ready | output | 1 | Transmit queue not empty |
| baud_tick | input | 1 | Baud-rate strobe used to time the transmit-empty delay |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Read data and the identification word are combinational and are due in the cycle of the read strobe. Every other result is due in the clock after the edge that takes the write, push, pop or tick. The bench drives each stimulus at a falling edge and releases it at the next one, and it samples outputs only there, after exactly one rising edge. The delayed transmit-empty cause is checked one tick before and on the `CHAR_TICKS`-th tick. Level, order and overflow are swept for all four receive levels.

// File: rtl/uart_fic_pkg.sv
package uart_fic_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'b000,
    CAUSE_THRE   = 3'b001,
    CAUSE_RXDATA = 3'b010,
    CAUSE_LINE   = 3'b011
  } cause_e;

  typedef struct packed {
    logic       en;
    logic       dma;
    logic [1:0] lvl_sel;
  } ctrl_t;

  function automatic logic [4:0] lvl_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    lvl_bytes = 5'd1;
      2'd1:    lvl_bytes = 5'd4;
      2'd2:    lvl_bytes = 5'd8;
      default: lvl_bytes = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_fic_fifo.sv
module uart_fic_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_slot,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = one_slot ? (cnt != '0) : (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt != '0);
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_nxt  = wr_ptr;
    rd_nxt  = rd_ptr;
    cnt_nxt = cnt;
    if (flush) begin
      wr_nxt  = '0;
      rd_nxt  = '0;
      cnt_nxt = '0;
    end else begin
      if (push_ok) wr_nxt = step(wr_ptr);
      if (pop_ok)  rd_nxt = step(rd_ptr);
      cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/uart_fic_thre.sv
module uart_fic_thre #(
  parameter int CHAR_TICKS = 16,
  parameter int CW         = 5,
  localparam int TW        = $clog2(CHAR_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] tx_cnt_nxt,
  input  logic          thr_wr,
  input  logic          iir_ack,
  output logic          thre
);
  logic          empty_evt, fire;
  logic          multi_q, multi_nxt;
  logic          dly_on, dly_on_nxt;
  logic [TW-1:0] dly_cnt, dly_cnt_nxt;
  logic          thre_nxt;

  assign empty_evt = (tx_cnt != '0) && (tx_cnt_nxt == '0);
  assign fire      = dly_on && baud_tick && (dly_cnt == TW'(CHAR_TICKS - 1)) && (tx_cnt == '0);

  always_comb begin
    multi_nxt = multi_q;
    if (empty_evt)                   multi_nxt = 1'b0;
    else if (tx_cnt_nxt >= CW'(2))   multi_nxt = 1'b1;

    dly_on_nxt  = dly_on;
    dly_cnt_nxt = dly_cnt;
    if (thr_wr) begin
      dly_on_nxt = 1'b0;
    end else if (empty_evt && !multi_q) begin
      dly_on_nxt  = 1'b1;
      dly_cnt_nxt = '0;
    end else if (fire) begin
      dly_on_nxt = 1'b0;
    end else if (dly_on && baud_tick) begin
      dly_cnt_nxt = dly_cnt + 1'b1;
    end

    thre_nxt = thre;
    if (thr_wr || iir_ack)        thre_nxt = 1'b0;
    else if (empty_evt && multi_q) thre_nxt = 1'b1;
    else if (fire)                 thre_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      multi_q <= 1'b0;
      dly_on  <= 1'b0;
      dly_cnt <= '0;
      thre    <= 1'b0;
    end else begin
      multi_q <= multi_nxt;
      dly_on  <= dly_on_nxt;
      dly_cnt <= dly_cnt_nxt;
      thre    <= thre_nxt;
    end
  end
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_fic_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CHAR_TICKS = 16,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_data,
  input  logic        rx_line_err,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  output logic        tx_ready,
  input  logic        baud_tick,
  output logic        irq,
  output logic        dma_rx_req,
  output logic        dma_tx_req
);
  ctrl_t          ctrl_q, ctrl_nxt;
  logic           wr_ctrl, wr_data, rd_data, rd_ctrl, en_flip;
  logic           rx_flush, tx_flush;
  logic [CW-1:0]  rx_cnt, rx_cnt_nxt, tx_cnt, tx_cnt_nxt;
  logic           rx_full, tx_full;
  logic [7:0]     rx_head;
  logic [4:0]     lvl;
  logic           rx_at_lvl, thre_pend, fifo_en;
  cause_e         cause;
  logic [31:0]    iir;
  logic           unused_bits;

  assign unused_bits = ^{reg_wdata[31:8], reg_wdata[5:4]};

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_ctrl  = reg_rd && (reg_addr == ADDR_CTRL);
  assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
  assign en_flip  = wr_ctrl && (reg_wdata[0] != ctrl_q.en);
  assign rx_flush = en_flip || (wr_ctrl && reg_wdata[0] && reg_wdata[1]);
  assign tx_flush = en_flip || (wr_ctrl && reg_wdata[0] && reg_wdata[2]);
  assign fifo_en  = ctrl_q.en;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt.en = reg_wdata[0];
      if (reg_wdata[0]) begin
        ctrl_nxt.dma     = reg_wdata[3];
        ctrl_nxt.lvl_sel = reg_wdata[7:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  uart_fic_fifo #(.DEPTH(DEPTH), .W(8)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .one_slot(!ctrl_q.en),
    .push(rx_push), .din(rx_data), .pop(rd_data), .dout(rx_head),
    .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt), .full(rx_full)
  );

  uart_fic_fifo #(.DEPTH(DEPTH), .W(8)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .one_slot(!ctrl_q.en),
    .push(wr_data), .din(reg_wdata[7:0]), .pop(tx_pop), .dout(tx_data),
    .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt), .full(tx_full)
  );

  assign lvl       = ctrl_q.en ? lvl_bytes(ctrl_q.lvl_sel) : 5'd1;
  assign rx_at_lvl = (int'(rx_cnt) >= int'(lvl));

  always_comb begin
    if (rx_line_err)    cause = CAUSE_LINE;
    else if (rx_at_lvl) cause = CAUSE_RXDATA;
    else if (thre_pend) cause = CAUSE_THRE;
    else                cause = CAUSE_NONE;
  end

  uart_fic_thre #(.CHAR_TICKS(CHAR_TICKS), .CW(CW)) thre_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_cnt(tx_cnt), .tx_cnt_nxt(tx_cnt_nxt), .thr_wr(wr_data),
    .iir_ack(rd_ctrl && (cause == CAUSE_THRE)), .thre(thre_pend)
  );

  assign iir = {24'd0, ctrl_q.en, ctrl_q.en, 2'b00, cause, (cause == CAUSE_NONE)};

  always_comb begin
    case (reg_addr)
      ADDR_DATA: reg_rdata = (rx_cnt != '0) ? {24'd0, rx_head} : 32'd0;
      ADDR_CTRL: reg_rdata = iir;
      default:   reg_rdata = 32'd0;
    endcase
  end

  assign irq        = (cause != CAUSE_NONE);
  assign tx_ready   = (tx_cnt != '0);
  assign dma_rx_req = ctrl_q.en && ctrl_q.dma && rx_at_lvl;
  assign dma_tx_req = ctrl_q.en && ctrl_q.dma && !tx_full;
endmodule

// File: rtl/uart_fifo_irq_ctrl_chk.sv
module uart_fifo_irq_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [2:0]    ctl_bits,
  input logic          iir_b0,
  input logic          irq,
  input logic          dma_rx_req,
  input logic          dma_tx_req,
  input logic          fifo_en,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          thre
);
  p_flush_on_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && ctl_bits[0] != fifo_en) |=> (rx_cnt == '0 && tx_cnt == '0));

  p_rx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && ctl_bits[0] && ctl_bits[1]) |=> (rx_cnt == '0));

  p_tx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && ctl_bits[0] && ctl_bits[2]) |=> (tx_cnt == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_cnt) <= DEPTH) && (int'(tx_cnt) <= DEPTH));

  p_thre_clr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> !thre);

  p_iir_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |-> (iir_b0 == !irq));

  p_dma_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!dma_rx_req && !dma_tx_req));

  p_dma_rx_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> irq);
endmodule

bind uart_fifo_irq_ctrl uart_fifo_irq_ctrl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .ctl_bits(reg_wdata[2:0]), .iir_b0(reg_rdata[0]), .irq(irq),
  .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .fifo_en(fifo_en),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .thre(thre_pend)
);

// File: tb/uart_fifo_irq_ctrl_tb_top.sv
module uart_fifo_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int TICKS      = 4;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_push, rx_line_err, tx_pop, baud_tick;
  logic [7:0]  rx_data, tx_data;
  logic        tx_ready, irq, dma_rx_req, dma_tx_req;

  int n_chk = 0;
  int n_bad = 0;

  uart_fifo_irq_ctrl #(.DEPTH(DEPTH), .CHAR_TICKS(TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_data(rx_data),
    .rx_line_err(rx_line_err), .tx_pop(tx_pop), .tx_data(tx_data), .tx_ready(tx_ready),
    .baud_tick(baud_tick), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_data = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    @(negedge clk); b = tx_data; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rx_push = 0; rx_data = 0; rx_line_err = 0; tx_pop = 0; baud_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 dma", {dma_rx_req, dma_tx_req}, 0);
    check("R1 tx_ready", tx_ready, 0);
    rd(2, d); check("R1 iir", d, 32'h01);

    // R2 enable
    wr(2, 32'h01);
    rd(2, d); check("R2 iir enabled", d, 32'hC1);

    // R4 level sweep, R5 order and overflow
    for (int t = 0; t < 4; t++) begin
      int lv;
      lv = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
      wr(2, (t << 6) | 32'h03);
      for (int k = 1; k <= 16; k++) begin
        push_rx(8'(t * 20 + k));
        check($sformatf("R4 lvl%0d cnt%0d", t, k), irq, (k >= lv));
      end
      push_rx(8'hEE);
      for (int j = 1; j <= 16; j++) begin
        rd(0, d); check($sformatf("R5 rx order %0d", j), d, t * 20 + j);
      end
      check("R5 drop on full", irq, 0);
    end

    // R3 receive reset
    wr(2, 32'h41);
    for (int k = 0; k < 5; k++) push_rx(8'(k));
    check("R3 pre", irq, 1);
    wr(2, 32'h43);
    check("R3 rx emptied", irq, 0);
    rd(2, d); check("R3 iir", d, 32'hC1);
    push_rx(8'h5A);
    rd(0, d); check("R3 new head", d, 32'h5A);

    // R3 transmit reset (R6: queue held 3 bytes)
    wr(0, 32'h01); wr(0, 32'h02); wr(0, 32'h03);
    wr(2, 32'h45);
    check("R3 tx emptied", tx_ready, 0);
    check("R6 after tx reset", irq, 1);
    rd(2, d); check("R6 iir thre", d, 32'hC2);
    check("R8 iir read clears", irq, 0);

    // R6 immediate
    wr(0, 32'h11); wr(0, 32'h22);
    pop_tx(b); check("R5 tx order 1", b, 8'h11);
    check("R6 not yet", irq, 0);
    pop_tx(b); check("R5 tx order 2", b, 8'h22);
    check("R6 immediate", irq, 1);
    rd(2, d); check("R6 iir", d, 32'hC2);

    // R7 delayed
    wr(0, 32'h33);
    pop_tx(b);
    check("R7 no immediate", irq, 0);
    for (int k = 0; k < TICKS - 1; k++) tick();
    check("R7 before last tick", irq, 0);
    tick();
    check("R7 on last tick", irq, 1);
    wr(0, 32'h44);
    check("R8 write clears", irq, 0);
    pop_tx(b);
    tick(); tick();
    wr(0, 32'h55);
    for (int k = 0; k < TICKS + 1; k++) tick();
    check("R7 write cancels", irq, 0);
    pop_tx(b);
    for (int k = 0; k < TICKS; k++) tick();
    check("R7 second delay", irq, 1);

    // R9 priority (level 4 from last control write)
    for (int k = 0; k < 4; k++) push_rx(8'h70 + 8'(k));
    @(negedge clk); rx_line_err = 1'b1;
    rd(2, d); check("R9 line top", d, 32'hC6);
    rx_line_err = 1'b0;
    rd(2, d); check("R9 rx level next", d, 32'hC4);
    rd(0, d); check("R5 rx head", d, 32'h70);
    rd(2, d); check("R9 thre kept", d, 32'hC2);
    check("R8 cleared by top read", irq, 0);

    // R10 DMA
    wr(2, 32'h0B);
    check("R10 tx req", dma_tx_req, 1);
    check("R10 rx req idle", dma_rx_req, 0);
    push_rx(8'h9C);
    check("R10 rx req", dma_rx_req, 1);
    for (int k = 0; k < DEPTH - 1; k++) wr(0, k);
    check("R10 tx req not full", dma_tx_req, 1);
    wr(0, 32'hFF);
    check("R10 tx req full", dma_tx_req, 0);

    // R11 reserved bits
    wr(2, 32'hFFFF_FF31);
    check("R11 dma off", {dma_rx_req, dma_tx_req}, 0);
    check("R11 tx kept", tx_ready, 1);
    rd(0, d); check("R11 rx kept", d, 32'h9C);
    wr(2, 32'h05);
    check("R6 full tx reset", irq, 1);
    rd(2, d);

    // R2 disable: flush, one slot, bits 7:1 ignored
    push_rx(8'h01); push_rx(8'h02);
    wr(2, 32'h0E);
    check("R2 flush on disable", irq, 0);
    check("R2 dma off", {dma_rx_req, dma_tx_req}, 0);
    rd(2, d); check("R2 iir disabled", d, 32'h01);
    push_rx(8'hA1);
    check("R2 level one", irq, 1);
    push_rx(8'hA2);
    rd(0, d); check("R2 one slot rx", d, 32'hA1);
    check("R2 second dropped", irq, 0);
    wr(0, 32'hB1); wr(0, 32'hB2);
    pop_tx(b); check("R2 one slot tx", b, 8'hB1);
    check("R2 tx drained", tx_ready, 0);
    wr(2, 32'h01);
    rd(2, d); check("R2 reenabled", d[7:6], 2'b11);

    finish_run();
  end
endmodule